// File: doc/BRIEF.md
# Frame-Synchronous Capture Window Controller

This block opens a write window into an external frame buffer for exactly the frame that follows a software capture request. It watches the camera's vertical sync and horizontal reference strobes, which arrive asynchronously and are brought into the system clock domain on chip. It drives the buffer's write-enable line and reports when the captured frame is complete. It also counts the lines of every frame and keeps the count of the most recent one.

The falling edge of vertical sync marks a frame boundary, and write-enable changes only there. A capture request marks the block busy and arms a pending flag. At the next boundary the window opens. At the boundary after that, the window closes, busy drops and a sticky done flag is raised. Software polls with a query strobe. The query answers false while busy is set. Otherwise it returns the done flag and clears it in the same operation, so a completed capture is reported once.

Top module: `capwin_top`

## Requirements
- R1: After reset, write-enable is low, busy is low, a query returns 0 and the last-frame line count is 0.
- R2: A capture request pulse sets busy in the following cycle and arms a pending request.
- R3: A frame boundary is a falling edge of vertical sync after a two-flop synchroniser. At a boundary with a request pending, write-enable goes high, done is cleared and the pending request is consumed.
- R4: At a boundary with no request pending, write-enable goes low. If busy was set, busy clears and done is set.
- R5: A query made while busy is set answers 0 one cycle later and leaves done unchanged.
- R6: A query made while busy is clear answers the done flag one cycle later and clears it, so an immediate second query answers 0.
- R7: Each rising edge of horizontal reference adds one to a line counter. At each boundary the count is copied to the last-frame line count output and the counter restarts from zero.
- R8: The line counter is LINE_W bits wide (default 10). It saturates at 2^LINE_W-1 (1023) and does not wrap.
- R9: A request that arrives in the same cycle as a boundary is not serviced at that boundary. It stays pending and busy stays set, and the window opens at the next boundary.
- R10: A rising edge of vertical sync does not change write-enable or busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_req_i | input | 1 | One-cycle capture request |
| done_query_i | input | 1 | One-cycle done query (read-and-clear) |
| vsync_i | input | 1 | Vertical sync from the camera, asynchronous |
| href_i | input | 1 | Horizontal reference from the camera, asynchronous |
| wr_en_o | output | 1 | Frame buffer write-enable |
| busy_o | output | 1 | A capture is pending or in progress |
| rsp_valid_o | output | 1 | Query answer valid, one cycle after a query |
| rsp_done_o | output | 1 | Query answer: capture complete |
| last_lines_o | output | LINE_W | Line count of the last completed frame |

## Verification
The hardest case to reach is a request that lands in the same cycle as the synchronised vertical sync fall. The request must miss that boundary and stay pending. The stimulus reaches this case by lowering vertical sync and then raising the request exactly two clock edges later, so that it meets the edge detector's output. The random frames also place requests and queries at arbitrary points inside the active period of each frame, and one long frame drives the line counter into saturation.

// File: rtl/capwin_pkg.sv
package capwin_pkg;
  typedef struct packed {
    logic pend;
    logic busy;
    logic done;
    logic we;
  } capwin_flags_t;
endpackage

// File: rtl/capwin_sync_edge.sv
module capwin_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~prev_q;
  assign fall_o = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/capwin_line_counter.sv
module capwin_line_counter #(
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_rise_i,
  input  logic              frame_fall_i,
  output logic [LINE_W-1:0] last_lines_o
);
  localparam logic [LINE_W-1:0] CNT_MAX = {LINE_W{1'b1}};

  logic [LINE_W-1:0] cnt_q, cnt_d, last_q;
  logic              cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (frame_fall_i) begin
      cnt_en = 1'b1;
      cnt_d  = line_rise_i ? LINE_W'(1) : '0;
    end else if (line_rise_i && (cnt_q != CNT_MAX)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + LINE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
    end else if (frame_fall_i) begin
      last_q <= cnt_q;
    end
  end

  assign last_lines_o = last_q;
endmodule

// File: rtl/capwin_ctrl.sv
module capwin_ctrl
  import capwin_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic query_i,
  input  logic frame_fall_i,
  output logic we_o,
  output logic busy_o,
  output logic rsp_valid_o,
  output logic rsp_done_o
);
  capwin_flags_t cur_q, nxt;
  logic          rsp_v_q, rsp_d_q, rsp_d_nxt;

  always_comb begin
    nxt       = cur_q;
    rsp_d_nxt = 1'b0;
    if (query_i && !cur_q.busy) begin
      rsp_d_nxt = cur_q.done;
      nxt.done  = 1'b0;
    end
    if (frame_fall_i) begin
      if (cur_q.pend) begin
        nxt.we   = 1'b1;
        nxt.done = 1'b0;
        nxt.busy = 1'b1;
      end else begin
        nxt.we = 1'b0;
        if (cur_q.busy) begin
          nxt.busy = 1'b0;
          nxt.done = 1'b1;
        end
        if (req_i) nxt.busy = 1'b1;
      end
      nxt.pend = req_i;
    end else if (req_i) begin
      nxt.pend = 1'b1;
      nxt.busy = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= '0;
      rsp_v_q <= 1'b0;
      rsp_d_q <= 1'b0;
    end else begin
      cur_q   <= nxt;
      rsp_v_q <= query_i;
      rsp_d_q <= rsp_d_nxt;
    end
  end

  assign we_o        = cur_q.we;
  assign busy_o      = cur_q.busy;
  assign rsp_valid_o = rsp_v_q;
  assign rsp_done_o  = rsp_d_q;
endmodule

// File: rtl/capwin_top.sv
module capwin_top #(
  parameter int LINE_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_req_i,
  input  logic              done_query_i,
  input  logic              vsync_i,
  input  logic              href_i,
  output logic              wr_en_o,
  output logic              busy_o,
  output logic              rsp_valid_o,
  output logic              rsp_done_o,
  output logic [LINE_W-1:0] last_lines_o
);
  logic vs_rise, vs_fall, hr_rise, hr_fall;

  capwin_sync_edge #(.STAGES(SYNC_STAGES)) u_vs_sync (
    .clk(clk), .rst_n(rst_n), .async_i(vsync_i), .rise_o(vs_rise), .fall_o(vs_fall)
  );

  capwin_sync_edge #(.STAGES(SYNC_STAGES)) u_hr_sync (
    .clk(clk), .rst_n(rst_n), .async_i(href_i), .rise_o(hr_rise), .fall_o(hr_fall)
  );

  capwin_line_counter #(.LINE_W(LINE_W)) u_lines (
    .clk(clk), .rst_n(rst_n), .line_rise_i(hr_rise), .frame_fall_i(vs_fall),
    .last_lines_o(last_lines_o)
  );

  capwin_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(cap_req_i), .query_i(done_query_i),
    .frame_fall_i(vs_fall), .we_o(wr_en_o), .busy_o(busy_o),
    .rsp_valid_o(rsp_valid_o), .rsp_done_o(rsp_done_o)
  );

  logic unused_edges;
  assign unused_edges = vs_rise ^ hr_fall;
endmodule

// File: rtl/capwin_checker.sv
module capwin_checker #(
  parameter int LINE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cap_req_i,
  input logic              done_query_i,
  input logic              vs_fall,
  input logic              wr_en_o,
  input logic              busy_o,
  input logic              rsp_valid_o,
  input logic              rsp_done_o,
  input logic [LINE_W-1:0] last_lines_o
);
  AST_REQ_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cap_req_i |=> busy_o); // R2

  AST_WE_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_fall |=> $stable(wr_en_o)); // R3

  AST_WE_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> busy_o); // R4

  AST_BUSY_QUERY_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_query_i && busy_o) |=> (rsp_valid_o && !rsp_done_o)); // R5

  AST_QUERY_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    done_query_i |=> rsp_valid_o); // R6

  AST_LAST_LINES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_fall |=> $stable(last_lines_o)); // R7

  AST_BOUNDARY_REQ_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_fall && cap_req_i && !wr_en_o && !busy_o) |=> (!wr_en_o && busy_o)); // R9
endmodule

bind capwin_top capwin_checker #(.LINE_W(LINE_W)) u_capwin_chk (
  .clk(clk), .rst_n(rst_n), .cap_req_i(cap_req_i), .done_query_i(done_query_i),
  .vs_fall(vs_fall), .wr_en_o(wr_en_o), .busy_o(busy_o),
  .rsp_valid_o(rsp_valid_o), .rsp_done_o(rsp_done_o), .last_lines_o(last_lines_o)
);

// File: tb/tb_capwin_top.sv
module tb_capwin_top;
  localparam int LINE_W = 10;
  localparam int LMAX   = (1 << LINE_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cap_req_i = 1'b0, done_query_i = 1'b0, vsync_i = 1'b0, href_i = 1'b0;
  logic wr_en_o, busy_o, rsp_valid_o, rsp_done_o;
  logic [LINE_W-1:0] last_lines_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  bit m_pend, m_busy, m_done, m_we;
  int m_last;

  always #10 clk = ~clk;

  capwin_top #(.LINE_W(LINE_W)) dut (
    .clk(clk), .rst_n(rst_n), .cap_req_i(cap_req_i), .done_query_i(done_query_i),
    .vsync_i(vsync_i), .href_i(href_i), .wr_en_o(wr_en_o), .busy_o(busy_o),
    .rsp_valid_o(rsp_valid_o), .rsp_done_o(rsp_done_o), .last_lines_o(last_lines_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int sat_lines(input int n);
    return (n > LMAX) ? LMAX : n;
  endfunction

  function automatic void model_boundary(input bit req, input int lines);
    if (m_pend) begin
      m_we = 1; m_done = 0; m_busy = 1;
    end else begin
      m_we = 0;
      if (m_busy) begin m_busy = 0; m_done = 1; end
      if (req) m_busy = 1;
    end
    m_pend = req;
    m_last = sat_lines(lines);
  endfunction

  task automatic do_req();
    cap_req_i = 1'b1; cyc(1); cap_req_i = 1'b0;
    m_pend = 1; m_busy = 1;
    chk(busy_o == 1'b1, "R2 busy after request", busy_o, 1);
  endtask

  task automatic do_query(input string tag);
    bit exp;
    exp = m_busy ? 1'b0 : m_done;
    if (!m_busy) m_done = 0;
    done_query_i = 1'b1; cyc(1); done_query_i = 1'b0;
    chk(rsp_valid_o && (rsp_done_o == exp), tag, rsp_done_o, exp);
  endtask

  task automatic frame(input int nl, input bit pre_req, input bit pre_q, input bit bnd_req);
    vsync_i = 1'b1; cyc(5);
    chk(wr_en_o == m_we, "R10 wr_en after vsync rise", wr_en_o, m_we);
    chk(busy_o == m_busy, "R10 busy after vsync rise", busy_o, m_busy);
    if (pre_req) do_req();
    if (pre_q) do_query(m_busy ? "R5 query while busy" : "R6 query while idle");
    for (int i = 0; i < nl; i++) begin
      href_i = 1'b1; cyc(2); href_i = 1'b0; cyc(2);
    end
    cyc(2);
    vsync_i = 1'b0;
    if (bnd_req) begin
      cyc(2); cap_req_i = 1'b1; cyc(1); cap_req_i = 1'b0;
    end else begin
      cyc(3);
    end
    cyc(3);
    model_boundary(bnd_req, nl);
    chk(wr_en_o == m_we, bnd_req ? "R9 wr_en at boundary" : "R3/R4 wr_en at boundary", wr_en_o, m_we);
    chk(busy_o == m_busy, bnd_req ? "R9 busy at boundary" : "R4 busy at boundary", busy_o, m_busy);
    chk(last_lines_o == m_last, (nl > LMAX) ? "R8 saturated count" : "R7 last lines", last_lines_o, m_last);
  endtask

  initial begin
    int wd = 0;
    while (!finished && wd < 190000) begin @(posedge clk); wd++; end
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_pend = 0; m_busy = 0; m_done = 0; m_we = 0; m_last = 0;
    cyc(3); rst_n = 1'b1; cyc(2);
    chk(wr_en_o == 1'b0, "R1 reset wr_en", wr_en_o, 0);
    chk(busy_o == 1'b0, "R1 reset busy", busy_o, 0);
    chk(last_lines_o == '0, "R1 reset last lines", last_lines_o, 0);
    do_query("R1 reset query");

    // directed: idle frame, capture, completion, read-and-clear
    frame(7, 0, 0, 0);
    frame(12, 1, 1, 0);
    chk(wr_en_o == 1'b1, "R3 window open", wr_en_o, 1);
    do_query("R5 query during capture");
    frame(5, 0, 0, 0);
    do_query("R6 first query after capture");
    chk(rsp_done_o == 1'b1, "R6 done reported", rsp_done_o, 1);
    do_query("R6 second query cleared");

    // directed: request coinciding with boundary
    frame(3, 0, 0, 1);
    chk(wr_en_o == 1'b0, "R9 not opened on same-cycle request", wr_en_o, 0);
    frame(4, 0, 0, 0);
    chk(wr_en_o == 1'b1, "R9 opened at next boundary", wr_en_o, 1);
    frame(2, 0, 0, 0);
    do_query("R6 done after deferred capture");

    // directed: saturation and empty frame
    frame(LMAX + 6, 0, 0, 0);
    frame(0, 0, 0, 0);

    // random frames
    for (int k = 0; k < 30; k++) begin
      frame(int'($urandom_range(0, 20)), bit'($urandom_range(0, 1)),
            bit'($urandom_range(0, 1)), ($urandom_range(0, 5) == 0));
      if ($urandom_range(0, 2) == 0) do_query(m_busy ? "R5 random query" : "R6 random query");
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule